// File: doc/BRIEF.md
# Start-up Offset Calibration Sequencer

This block sits behind the decimation stage of a two-channel converter and removes its DC offset. When the active-low run input `rst_n` is released, the block starts a calibration window that lasts a fixed number of word-clock periods. During that window `cal_busy` is high. Each channel's offset is the floor average of the final samples of the window, and it is stored in a per-channel register.

From then on, the stored offset is subtracted from every sample of that channel, and the result is clipped to the 24-bit two's-complement range. `ref_sel` tells the analog multiplexer which source to present during calibration: the common-mode level or the real inputs. The corrected data outputs stay at zero until a later data-valid point.

The speed mode doubles every count. Slave-style frame timing pushes both the busy-low point and the data-valid point one word period later. Word-clock rising edges arrive as one-cycle `word_tick` pulses in the `clk` domain, and the samples for both channels arrive with them.

Top module: `adc_offcal_top`

## Requirements
- R1: While `rst_n` is low, `cal_busy` and `data_valid` are low and both data outputs are zero.
- R2: `cal_busy` rises at the first `clk` edge after `rst_n` goes high.
- R3: `cal_busy` falls at the edge that registers word tick number CAL_NORM, counted from the start. This is 8704 by default, or twice that with `fast_mode` high.
- R4: `data_valid` rises at the edge that registers word tick VALID_NORM, which is 8960 by default, or twice that in fast mode. Both data outputs stay zero before this point.
- R5: With `slave_timing` high, the busy-low point and the data-valid point are each one word tick later.
- R6: `fast_mode` and `slave_timing` are sampled when calibration starts. Changes to them during a run have no effect on that run.
- R7: Each channel's offset is floor((sum of the last 2^AVG_LOG2 samples of the window) / 2^AVG_LOG2). AVG_LOG2 is 8 by default.
- R8: From the data-valid tick onward, each word tick loads an output with (sample − offset) for its channel. The output holds between ticks.
- R9: A corrected value above 0x7FFFFF is output as 0x7FFFFF, and one below −0x800000 is output as 0x800000.
- R10: While `cal_busy` is high, `ref_sel` equals `cal_src` (0 selects the common-mode reference, 1 selects the analog inputs). Otherwise `ref_sel` is 1.
- R11: Taking `rst_n` low in the middle of a run aborts it. The next release restarts counting from tick zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low run/reset; rising edge starts calibration |
| word_tick | input | 1 | One-cycle pulse per word-clock rising edge |
| fast_mode | input | 1 | 1 = double-speed counts |
| slave_timing | input | 1 | 1 = slave frame timing (one word later) |
| cal_src | input | 1 | Calibration source choice: 0 common-mode, 1 inputs |
| smp_left | input | DATA_W | Left sample, valid with word_tick |
| smp_right | input | DATA_W | Right sample, valid with word_tick |
| cal_busy | output | 1 | Calibration in progress |
| ref_sel | output | 1 | Reference select to the analog multiplexer |
| data_valid | output | 1 | Corrected data is being delivered |
| out_left | output | DATA_W | Corrected, clipped left sample |
| out_right | output | DATA_W | Corrected, clipped right sample |

## Verification
Most faults in the tick counter or the latched mode bits show up as a busy fall or data-valid rise on the wrong word tick. Those are visible on the very tick where the count diverges. A wrong accumulation window or a wrong shift leaves an offset error, and that error appears in the first corrected sample after data-valid. A missing clip appears as a wrapped sign on the extreme samples driven after valid. A stale state after an aborted run shows up as a shortened window on the following run.

// File: rtl/adc_offcal_pkg.sv
package adc_offcal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAL  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } cal_state_e;
endpackage

// File: rtl/adc_offcal_ctrl.sv
module adc_offcal_ctrl
    import adc_offcal_pkg::*;
#(
    parameter int CAL_NORM   = 8704,
    parameter int VALID_NORM = 8960,
    parameter int AVG_LOG2   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_tick,
    input  logic fast_mode,
    input  logic slave_timing,
    output logic busy,
    output logic data_valid,
    output logic acc_en,
    output logic acc_last,
    output logic out_en
);
    localparam int CAL_FAST   = 2 * CAL_NORM;
    localparam int VALID_FAST = 2 * VALID_NORM;
    localparam int AVG_N      = 1 << AVG_LOG2;
    localparam int CW         = $clog2(VALID_FAST + 2);

    typedef struct packed {
        cal_state_e    state;
        logic [CW-1:0] cnt;
        logic          fast;
        logic          slave;
        logic          dv;
    } ctrl_t;

    ctrl_t q, d;
    logic [CW-1:0] tick_no, cal_end, valid_end;

    always_comb begin
        d        = q;
        acc_en   = 1'b0;
        acc_last = 1'b0;
        out_en   = q.dv;
        tick_no  = q.cnt + CW'(1);
        cal_end  = (q.fast ? CW'(CAL_FAST) : CW'(CAL_NORM)) + CW'(q.slave);
        valid_end = (q.fast ? CW'(VALID_FAST) : CW'(VALID_NORM)) + CW'(q.slave);
        case (q.state)
            ST_IDLE: begin
                d.state = ST_CAL;
                d.cnt   = '0;
                d.fast  = fast_mode;
                d.slave = slave_timing;
                d.dv    = 1'b0;
            end
            ST_CAL: begin
                if (word_tick) begin
                    d.cnt = tick_no;
                    if (tick_no > cal_end - CW'(AVG_N)) acc_en = 1'b1;
                    if (tick_no == cal_end) begin
                        acc_last = 1'b1;
                        d.state  = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (word_tick) begin
                    d.cnt = tick_no;
                    if (tick_no == valid_end) begin
                        d.state = ST_DONE;
                        d.dv    = 1'b1;
                        out_en  = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, fast: 1'b0, slave: 1'b0, dv: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.state == ST_CAL);
    assign data_valid = q.dv;

    assert_busy_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(word_tick));
    assert_valid_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !busy);
    assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> data_valid);
    assert_valid_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> $past(word_tick));
endmodule

// File: rtl/adc_offcal_chan.sv
module adc_offcal_chan #(
    parameter int DATA_W   = 24,
    parameter int AVG_LOG2 = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_tick,
    input  logic                     acc_en,
    input  logic                     acc_last,
    input  logic                     out_en,
    input  logic signed [DATA_W-1:0] sample_in,
    output logic        [DATA_W-1:0] out_q
);
    localparam int AW = DATA_W + AVG_LOG2;
    localparam logic signed [DATA_W:0] POS_LIM = {2'b00, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W:0] NEG_LIM = {2'b11, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic signed [AW-1:0]     acc;
        logic signed [DATA_W-1:0] off;
        logic        [DATA_W-1:0] dout;
    } chan_t;

    chan_t q, d;
    logic signed [AW-1:0]     sum;
    logic signed [DATA_W:0]   diff;
    logic        [DATA_W-1:0] clipped;

    always_comb begin
        d    = q;
        sum  = q.acc + AW'(sample_in);
        diff = (DATA_W+1)'(sample_in) - (DATA_W+1)'(q.off);
        if (diff > POS_LIM)      clipped = POS_LIM[DATA_W-1:0];
        else if (diff < NEG_LIM) clipped = NEG_LIM[DATA_W-1:0];
        else                     clipped = diff[DATA_W-1:0];
        if (acc_en) begin
            if (acc_last) begin
                d.off = DATA_W'(sum >>> AVG_LOG2);
                d.acc = '0;
            end else begin
                d.acc = sum;
            end
        end
        if (word_tick) d.dout = out_en ? clipped : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_q = q.dout;

    assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_tick |=> $stable(out_q));
    assert_acc_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> word_tick);
endmodule

// File: rtl/adc_offcal_top.sv
module adc_offcal_top #(
    parameter int DATA_W     = 24,
    parameter int CAL_NORM   = 8704,
    parameter int VALID_NORM = 8960,
    parameter int AVG_LOG2   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_tick,
    input  logic              fast_mode,
    input  logic              slave_timing,
    input  logic              cal_src,
    input  logic [DATA_W-1:0] smp_left,
    input  logic [DATA_W-1:0] smp_right,
    output logic              cal_busy,
    output logic              ref_sel,
    output logic              data_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    localparam int NCH = 2;

    logic acc_en, acc_last, out_en;
    logic [DATA_W-1:0] smp_v [NCH];
    logic [DATA_W-1:0] out_v [NCH];

    adc_offcal_ctrl #(
        .CAL_NORM(CAL_NORM), .VALID_NORM(VALID_NORM), .AVG_LOG2(AVG_LOG2)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .word_tick(word_tick),
        .fast_mode(fast_mode), .slave_timing(slave_timing),
        .busy(cal_busy), .data_valid(data_valid),
        .acc_en(acc_en), .acc_last(acc_last), .out_en(out_en)
    );

    assign smp_v[0] = smp_left;
    assign smp_v[1] = smp_right;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        adc_offcal_chan #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) chan_i (
            .clk(clk), .rst_n(rst_n), .word_tick(word_tick),
            .acc_en(acc_en), .acc_last(acc_last), .out_en(out_en),
            .sample_in(smp_v[c]), .out_q(out_v[c])
        );
    end

    assign out_left  = out_v[0];
    assign out_right = out_v[1];
    assign ref_sel   = cal_busy ? cal_src : 1'b1;

    assert_zero_before_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (out_left == '0 && out_right == '0));
    assert_src_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && $stable(cal_src) && $past(cal_busy)) |-> $stable(ref_sel));
endmodule

// File: tb/adc_offcal_top_tb_top.sv
module adc_offcal_top_tb_top;
    localparam int PERIOD = 10;
    localparam int DW = 24, CN = 24, VN = 30, AL = 3;
    localparam int AVG_N = 1 << AL;

    logic clk = 1'b0, rst_n = 1'b0, word_tick = 1'b0;
    logic fast_mode = 1'b0, slave_timing = 1'b0, cal_src = 1'b0;
    logic [DW-1:0] smp_left = '0, smp_right = '0;
    logic cal_busy, ref_sel, data_valid;
    logic [DW-1:0] out_left, out_right;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    adc_offcal_top #(.DATA_W(DW), .CAL_NORM(CN), .VALID_NORM(VN), .AVG_LOG2(AL)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_tick(word_tick), .fast_mode(fast_mode),
        .slave_timing(slave_timing), .cal_src(cal_src), .smp_left(smp_left),
        .smp_right(smp_right), .cal_busy(cal_busy), .ref_sel(ref_sel),
        .data_valid(data_valid), .out_left(out_left), .out_right(out_right));

    function automatic longint clip(longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic longint sx(logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_chk_r1(string tag);
        chk(cal_busy == 1'b0, {tag, " R1 busy"}, cal_busy, 0);
        chk(data_valid == 1'b0, {tag, " R1 valid"}, data_valid, 0);
        chk(out_left == '0 && out_right == '0, {tag, " R1 outputs"}, sx(out_left), 0);
    endtask

    task automatic run(bit fast, bit slave, bit src, int base_l, int base_r,
                       int abort_at, bit flip, int post);
        int cal_end = (fast ? 2*CN : CN) + int'(slave);
        int val_end = (fast ? 2*VN : VN) + int'(slave);
        longint sum_l = 0, sum_r = 0, off_l = 0, off_r = 0;
        longint exp_l = 0, exp_r = 0;
        rst_n = 1'b0;
        fast_mode = fast; slave_timing = slave; cal_src = src;
        repeat (3) @(negedge clk);
        idle_chk_r1("reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(cal_busy == 1'b1, "R2 busy rises one clock after release", cal_busy, 1);
        chk(ref_sel == src, "R10 ref_sel follows source during busy", ref_sel, src);
        for (int k = 1; k <= val_end + post; k++) begin
            int sl, sr;
            if (k <= val_end) begin
                sl = base_l + int'($urandom % 64) - 32;
                sr = base_r + int'($urandom % 64) - 32;
            end else if (k == val_end + 1) begin
                sl = 8388607; sr = -8388608;
            end else if (k == val_end + 2) begin
                sl = -8388608; sr = 8388607;
            end else begin
                sl = int'($urandom % 4000000) - 2000000;
                sr = int'($urandom % 4000000) - 2000000;
            end
            smp_left = DW'(sl); smp_right = DW'(sr);
            word_tick = 1'b1;
            @(negedge clk);
            word_tick = 1'b0;
            if (flip && k == 3) begin
                fast_mode = ~fast_mode; slave_timing = ~slave_timing;
            end
            if (k > cal_end - AVG_N && k <= cal_end) begin
                sum_l += sl; sum_r += sr;
            end
            if (k == cal_end) begin
                off_l = sum_l >>> AL; off_r = sum_r >>> AL;
            end
            if (abort_at != 0 && k == abort_at) begin
                rst_n = 1'b0;
                @(negedge clk);
                idle_chk_r1("abort R11");
                return;
            end
            if (k == cal_end - 1)
                chk(cal_busy == 1'b1, "R3/R5/R6 busy still high before end", cal_busy, 1);
            if (k == cal_end) begin
                chk(cal_busy == 1'b0, "R3/R5/R6 busy low at window end", cal_busy, 0);
                chk(ref_sel == 1'b1, "R10 ref_sel high after busy", ref_sel, 1);
            end
            if (k < val_end) begin
                chk(data_valid == 1'b0, "R4/R5 valid low before point", data_valid, 0);
                chk(out_left == '0 && out_right == '0, "R4 outputs held zero",
                    sx(out_left), 0);
            end else begin
                exp_l = clip(longint'(sl) - off_l);
                exp_r = clip(longint'(sr) - off_r);
                if (k == val_end)
                    chk(data_valid == 1'b1, "R4/R5 valid rises at point", data_valid, 1);
                if (k <= val_end + 2) begin
                    chk(sx(out_left) == exp_l, "R7/R8/R9 left corrected", sx(out_left), exp_l);
                    chk(sx(out_right) == exp_r, "R7/R8/R9 right corrected", sx(out_right), exp_r);
                end else begin
                    chk(sx(out_left) == exp_l, "R8 left random", sx(out_left), exp_l);
                    chk(sx(out_right) == exp_r, "R8 right random", sx(out_right), exp_r);
                end
            end
            smp_left = DW'($urandom); smp_right = DW'($urandom);
            repeat (3) @(negedge clk);
            if (k >= val_end)
                chk(sx(out_left) == exp_l && sx(out_right) == exp_r,
                    "R8 outputs hold between ticks", sx(out_left), exp_l);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        run(1'b0, 1'b0, 1'b0, -1000, 5000, 0, 1'b0, 6);
        run(1'b1, 1'b0, 1'b1, 7000, -3000, 0, 1'b0, 6);
        run(1'b0, 1'b1, 1'b1, 123, -77, 0, 1'b0, 4);
        run(1'b1, 1'b1, 1'b0, -20, 40, 0, 1'b0, 4);
        run(1'b0, 1'b0, 1'b0, 500, 500, 0, 1'b1, 3);   // R6 flip mid-run
        run(1'b0, 1'b0, 1'b0, 0, 0, 10, 1'b0, 0);       // R11 abort
        run(1'b0, 1'b0, 1'b1, -300, 900, 0, 1'b0, 3);   // R11 restart
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule